// File: doc/BRIEF.md
# Owner-Pointer Home Directory for Lazy Coherence

This block is the home node of a lazy cache coherence scheme. For every line it keeps a coherence state, the current data value and a single owner identifier. There is never a list of sharers. Because sharers are not tracked, the directory never sends invalidations. Caches that hold shared copies drop them on their own. The directory keeps the most recent value of each line. It takes the line's value from ownership handovers and from writebacks sent by the owner.

Caches send four kinds of message to one request port: read requests, exclusive requests, data writebacks and grant acknowledgements. The directory replies on one response port. A reply is either a shared or an exclusive data grant to the requester, or a forward to the current owner. A line whose ownership is in flight is in a waiting state: it waits either for an acknowledgement or for data. A request that reaches such a line is parked in a one-entry pending register. It is replayed once the line settles.

Top module: `owner_dir`

## Requirements
- R1: After reset every line is Invalid with value 0 and owner 0, `rsp_valid` is low and `req_ready` is high.
- R2: A read request (type 0) to an Invalid line returns a shared grant (type 1) to the requester with the stored value. It records the requester as owner, and the line then waits for that owner's acknowledgement.
- R3: A read request to a Shared line returns a shared grant with the stored value and leaves state and owner unchanged.
- R4: An exclusive request (type 1) to an Invalid or Shared line returns an exclusive grant (type 2) to the requester. It makes the requester the owner, and the line then waits for an acknowledgement.
- R5: Any request from the recorded owner of an Exclusive line returns an exclusive grant to it with the stored value, and the line stays Exclusive.
- R6: A read request to an Exclusive line from another cache sends a shared forward (type 3) to the owner, carrying the requester id in `rsp_src`. The line then waits for data. A data message (type 2) from the owner then stores its value and makes the line Shared.
- R7: An exclusive request to an Exclusive line from another cache sends an exclusive forward (type 4) to the old owner. It moves the owner pointer to the requester, and the line then waits for an acknowledgement. An exclusive grant only ever goes to the recorded owner.
- R8: An acknowledgement (type 3) from the owner of a line waiting for one makes the line Exclusive. An acknowledgement or data message from any other cache, or in any other state, changes nothing.
- R9: A data message from the owner of an Exclusive line stores its value, and the line stays Exclusive.
- R10: A request to a waiting line is parked in the pending register without a reply. While it is parked, further requests see `req_ready` low, but data and acknowledgements are still accepted. Once its line settles, the parked request is replayed ahead of new input.
- R11: A reply appears on the response port in the cycle after the request is accepted or replayed. Data and acknowledgement messages produce no reply.
- R12: Response type codes are 1 shared grant, 2 exclusive grant, 3 shared forward, 4 exclusive forward, and `rsp_valid` never shows code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Incoming message present |
| req_ready | output | 1 | Message taken this cycle if valid |
| req_src | input | ID_W | Sending cache id |
| req_type | input | 2 | 0 read, 1 exclusive, 2 data, 3 ack |
| req_addr | input | AW | Line index |
| req_val | input | VAL_W | Data carried by a data message |
| rsp_valid | output | 1 | Reply present |
| rsp_type | output | 3 | Reply code (R12) |
| rsp_dst | output | ID_W | Destination cache |
| rsp_src | output | ID_W | Cache the reply acts for (the requester) |
| rsp_addr | output | AW | Line index |
| rsp_val | output | VAL_W | Stored line value |

## Verification
The bench builds the block with its defaults: four caches, eight lines and 8-bit values. It aims random traffic at only four of the lines, so requests collide with lines that are waiting. This keeps the pending register busy and forces replays. Data and acknowledgements are biased toward the line's current owner, so ownership handovers and writebacks complete often. Messages from non-owners still arrive to exercise the ignore rules. A reference model in the bench predicts `req_ready` and every reply.

// File: rtl/odir_pkg.sv
package odir_pkg;

    typedef enum logic [2:0] {
        LS_INV   = 3'd0,
        LS_SHD   = 3'd1,
        LS_EXC   = 3'd2,
        LS_WACK  = 3'd3,
        LS_WDATA = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        MT_GETS = 2'd0,
        MT_GETX = 2'd1,
        MT_DATA = 2'd2,
        MT_ACK  = 2'd3
    } in_msg_e;

    typedef enum logic [2:0] {
        OT_NONE  = 3'd0,
        OT_DATAS = 3'd1,
        OT_DATAX = 3'd2,
        OT_FWDS  = 3'd3,
        OT_FWDX  = 3'd4
    } out_msg_e;

    function automatic logic is_waiting(line_st_e s);
        return (s == LS_WACK) || (s == LS_WDATA);
    endfunction

endpackage

// File: rtl/odir_line_store.sv
module odir_line_store
    import odir_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int ID_W   = 2,
    parameter int VAL_W  = 8,
    localparam int AW    = $clog2(NLINES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [AW-1:0]                ra_addr,
    output line_st_e                     ra_state,
    output logic [ID_W-1:0]              ra_owner,
    output logic [VAL_W-1:0]             ra_value,
    input  logic [AW-1:0]                rb_addr,
    output line_st_e                     rb_state,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  line_st_e                     wr_state,
    input  logic [ID_W-1:0]              wr_owner,
    input  logic [VAL_W-1:0]             wr_value,
    output logic [NLINES-1:0][2:0]       st_flat,
    output logic [NLINES-1:0][ID_W-1:0]  own_flat
);

    logic [NLINES-1:0][2:0]      st_q;
    logic [NLINES-1:0][ID_W-1:0] own_q;
    logic [NLINES-1:0][VAL_W-1:0] val_q;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic sel;
        assign sel = wr_en && (wr_addr == AW'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i]  <= LS_INV;
                own_q[i] <= '0;
                val_q[i] <= '0;
            end else if (sel) begin
                st_q[i]  <= wr_state;
                own_q[i] <= wr_owner;
                val_q[i] <= wr_value;
            end
        end
    end

    assign ra_state = line_st_e'(st_q[ra_addr]);
    assign ra_owner = own_q[ra_addr];
    assign ra_value = val_q[ra_addr];
    assign rb_state = line_st_e'(st_q[rb_addr]);
    assign st_flat  = st_q;
    assign own_flat = own_q;

endmodule

// File: rtl/odir_pending.sv
module odir_pending #(
    parameter int ID_W = 2,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            clear,
    input  logic [ID_W-1:0] ld_src,
    input  logic [AW-1:0]   ld_addr,
    input  logic            ld_excl,
    output logic            p_valid,
    output logic [ID_W-1:0] p_src,
    output logic [AW-1:0]   p_addr,
    output logic            p_excl
);

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] src;
        logic [AW-1:0]   addr;
        logic            excl;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clear) begin
            pend_d.valid = 1'b0;
        end
        if (load) begin
            pend_d.valid = 1'b1;
            pend_d.src   = ld_src;
            pend_d.addr  = ld_addr;
            pend_d.excl  = ld_excl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign p_valid = pend_q.valid;
    assign p_src   = pend_q.src;
    assign p_addr  = pend_q.addr;
    assign p_excl  = pend_q.excl;

endmodule

// File: rtl/odir_decide.sv
module odir_decide
    import odir_pkg::*;
#(
    parameter int ID_W  = 2,
    parameter int VAL_W = 8
) (
    input  in_msg_e          m_type,
    input  logic [ID_W-1:0]  m_src,
    input  logic [VAL_W-1:0] m_val,
    input  line_st_e         l_state,
    input  logic [ID_W-1:0]  l_owner,
    input  logic [VAL_W-1:0] l_value,
    output logic             n_we,
    output line_st_e         n_state,
    output logic [ID_W-1:0]  n_owner,
    output logic [VAL_W-1:0] n_value,
    output logic             hold,
    output out_msg_e         o_type,
    output logic [ID_W-1:0]  o_dst
);

    logic from_owner;
    assign from_owner = (m_src == l_owner);

    always_comb begin
        n_we    = 1'b0;
        n_state = l_state;
        n_owner = l_owner;
        n_value = l_value;
        hold    = 1'b0;
        o_type  = OT_NONE;
        o_dst   = m_src;
        unique case (m_type)
            MT_GETS, MT_GETX: begin
                if (is_waiting(l_state)) begin
                    hold = 1'b1;
                end else if (l_state == LS_EXC) begin
                    if (from_owner) begin
                        o_type = OT_DATAX;
                    end else if (m_type == MT_GETS) begin
                        o_type  = OT_FWDS;
                        o_dst   = l_owner;
                        n_we    = 1'b1;
                        n_state = LS_WDATA;
                    end else begin
                        o_type  = OT_FWDX;
                        o_dst   = l_owner;
                        n_we    = 1'b1;
                        n_owner = m_src;
                        n_state = LS_WACK;
                    end
                end else if (m_type == MT_GETS && l_state == LS_SHD) begin
                    o_type = OT_DATAS;
                end else begin
                    o_type  = (m_type == MT_GETS) ? OT_DATAS : OT_DATAX;
                    n_we    = 1'b1;
                    n_owner = m_src;
                    n_state = LS_WACK;
                end
            end
            MT_DATA: begin
                if (from_owner && (l_state == LS_WDATA || l_state == LS_EXC)) begin
                    n_we    = 1'b1;
                    n_value = m_val;
                    n_state = (l_state == LS_WDATA) ? LS_SHD : LS_EXC;
                end
            end
            MT_ACK: begin
                if (from_owner && l_state == LS_WACK) begin
                    n_we    = 1'b1;
                    n_state = LS_EXC;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/owner_dir.sv
module owner_dir
    import odir_pkg::*;
#(
    parameter int NPROCS = 4,
    parameter int NLINES = 8,
    parameter int VAL_W  = 8,
    localparam int ID_W  = $clog2(NPROCS),
    localparam int AW    = $clog2(NLINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ID_W-1:0]  req_src,
    input  logic [1:0]       req_type,
    input  logic [AW-1:0]    req_addr,
    input  logic [VAL_W-1:0] req_val,
    output logic             rsp_valid,
    output logic [2:0]       rsp_type,
    output logic [ID_W-1:0]  rsp_dst,
    output logic [ID_W-1:0]  rsp_src,
    output logic [AW-1:0]    rsp_addr,
    output logic [VAL_W-1:0] rsp_val
);

    typedef struct packed {
        logic             valid;
        logic [2:0]       kind;
        logic [ID_W-1:0]  dst;
        logic [ID_W-1:0]  src;
        logic [AW-1:0]    addr;
        logic [VAL_W-1:0] val;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic             p_valid, p_excl;
    logic [ID_W-1:0]  p_src;
    logic [AW-1:0]    p_addr;
    line_st_e         p_line_state;
    logic             replay, take, act, in_is_get;

    in_msg_e          m_type;
    logic [ID_W-1:0]  m_src;
    logic [AW-1:0]    m_addr;
    logic [VAL_W-1:0] m_val;

    line_st_e         l_state, n_state;
    logic [ID_W-1:0]  l_owner, n_owner, o_dst;
    logic [VAL_W-1:0] l_value, n_value;
    logic             n_we, hold;
    out_msg_e         o_type;

    logic [NLINES-1:0][2:0]     st_flat;
    logic [NLINES-1:0][ID_W-1:0] own_flat;

    assign in_is_get = !req_type[1];
    assign replay    = p_valid && !is_waiting(p_line_state);
    assign req_ready = !replay && !(p_valid && in_is_get);
    assign take      = req_valid && req_ready;
    assign act       = replay || take;

    assign m_type = replay ? (p_excl ? MT_GETX : MT_GETS) : in_msg_e'(req_type);
    assign m_src  = replay ? p_src  : req_src;
    assign m_addr = replay ? p_addr : req_addr;
    assign m_val  = req_val;

    odir_line_store #(.NLINES(NLINES), .ID_W(ID_W), .VAL_W(VAL_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_addr  (m_addr),
        .ra_state (l_state),
        .ra_owner (l_owner),
        .ra_value (l_value),
        .rb_addr  (p_addr),
        .rb_state (p_line_state),
        .wr_en    (act && n_we),
        .wr_addr  (m_addr),
        .wr_state (n_state),
        .wr_owner (n_owner),
        .wr_value (n_value),
        .st_flat  (st_flat),
        .own_flat (own_flat)
    );

    odir_decide #(.ID_W(ID_W), .VAL_W(VAL_W)) u_decide (
        .m_type  (m_type),
        .m_src   (m_src),
        .m_val   (m_val),
        .l_state (l_state),
        .l_owner (l_owner),
        .l_value (l_value),
        .n_we    (n_we),
        .n_state (n_state),
        .n_owner (n_owner),
        .n_value (n_value),
        .hold    (hold),
        .o_type  (o_type),
        .o_dst   (o_dst)
    );

    odir_pending #(.ID_W(ID_W), .AW(AW)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take && hold),
        .clear   (replay),
        .ld_src  (req_src),
        .ld_addr (req_addr),
        .ld_excl (req_type[0]),
        .p_valid (p_valid),
        .p_src   (p_src),
        .p_addr  (p_addr),
        .p_excl  (p_excl)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = act && (o_type != OT_NONE);
        rsp_d.kind  = o_type;
        rsp_d.dst   = o_dst;
        rsp_d.src   = m_src;
        rsp_d.addr  = m_addr;
        rsp_d.val   = l_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_type  = rsp_q.kind;
    assign rsp_dst   = rsp_q.dst;
    assign rsp_src   = rsp_q.src;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_val   = rsp_q.val;

endmodule

// File: rtl/odir_chk.sv
module odir_chk #(
    parameter int NLINES = 8,
    parameter int ID_W   = 2,
    parameter int AW     = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic [1:0]                  req_type,
    input logic [ID_W-1:0]             req_src,
    input logic [AW-1:0]               req_addr,
    input logic                        rsp_valid,
    input logic [2:0]                  rsp_type,
    input logic [ID_W-1:0]             rsp_dst,
    input logic [ID_W-1:0]             rsp_src,
    input logic [AW-1:0]               rsp_addr,
    input logic                        replay,
    input logic                        p_valid,
    input logic [AW-1:0]               p_addr,
    input logic [NLINES-1:0][2:0]      st_flat,
    input logic [NLINES-1:0][ID_W-1:0] own_flat
);

    // R11: a reply is always caused by an accepted or replayed request
    assert_rsp_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(replay || (req_valid && req_ready && !req_type[1])));

    // R12: valid replies carry a defined code
    assert_rsp_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_type >= 3'd1 && rsp_type <= 3'd4));

    // R7: exclusive grants only reach the recorded owner
    assert_datax_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_type == 3'd2) |-> (own_flat[rsp_addr] == rsp_dst));

    // R6/R7: forwards never go back to the requester
    assert_fwd_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_type >= 3'd3) |-> (rsp_dst != rsp_src));

    // R10: a parked request is kept until it is replayed
    assert_pend_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && !replay) |=> (p_valid && $stable(p_addr)));

    // R8: owner acknowledgement settles a waiting line
    assert_ack_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_type == 2'd3 && st_flat[req_addr] == 3'd3
         && own_flat[req_addr] == req_src) |=> (st_flat[$past(req_addr)] == 3'd2));

endmodule

bind owner_dir odir_chk #(.NLINES(NLINES), .ID_W(ID_W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_type  (req_type),
    .req_src   (req_src),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_type  (rsp_type),
    .rsp_dst   (rsp_dst),
    .rsp_src   (rsp_src),
    .rsp_addr  (rsp_addr),
    .replay    (replay),
    .p_valid   (p_valid),
    .p_addr    (p_addr),
    .st_flat   (st_flat),
    .own_flat  (own_flat)
);

// File: tb/owner_dir_tb.sv
module owner_dir_tb;

    localparam int NP = 4;
    localparam int NL = 8;
    localparam int VW = 8;
    localparam int IW = 2;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready;
    logic [IW-1:0] req_src;
    logic [1:0]    req_type;
    logic [AW-1:0] req_addr;
    logic [VW-1:0] req_val;
    logic          rsp_valid;
    logic [2:0]    rsp_type;
    logic [IW-1:0] rsp_dst, rsp_src;
    logic [AW-1:0] rsp_addr;
    logic [VW-1:0] rsp_val;

    always #5 clk = ~clk;

    owner_dir #(.NPROCS(NP), .NLINES(NL), .VAL_W(VW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_type(req_type), .req_addr(req_addr), .req_val(req_val),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_dst(rsp_dst),
        .rsp_src(rsp_src), .rsp_addr(rsp_addr), .rsp_val(rsp_val)
    );

    // model state codes: 0 Invalid, 1 Shared, 2 Exclusive, 3 wait ack, 4 wait data
    int mst[NL], mown[NL], mval[NL];
    bit pv, px;
    int psrc, paddr;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic decide(input int s, o, v, src, typ, mv,
                          output int ns, no, nv, output bit hold,
                          output int ot, odst, output string tag);
        ns = s; no = o; nv = v; hold = 0; ot = 0; odst = src; tag = "R8";
        if (typ < 2) begin
            if (s >= 3) begin hold = 1; tag = "R10"; end
            else if (s == 2 && o == src) begin ot = 2; tag = "R5"; end
            else if (s == 2 && typ == 0) begin ot = 3; odst = o; ns = 4; tag = "R6"; end
            else if (s == 2) begin ot = 4; odst = o; no = src; ns = 3; tag = "R7"; end
            else if (typ == 0 && s == 1) begin ot = 1; tag = "R3"; end
            else if (typ == 0) begin ot = 1; no = src; ns = 3; tag = "R2"; end
            else begin ot = 2; no = src; ns = 3; tag = "R4"; end
        end else if (typ == 2) begin
            if (src == o && s == 4) begin nv = mv; ns = 1; tag = "R6"; end
            else if (src == o && s == 2) begin nv = mv; tag = "R9"; end
        end else begin
            if (src == o && s == 3) ns = 2;
        end
    endtask

    task automatic step(bit v, int src, int typ, int addr, int val);
        bit replay, rdy, act, hold, ev;
        int ms, mt, ma, ns, no, nv, ot, od;
        string tag;
        @(negedge clk);
        req_valid = v; req_src = IW'(src); req_type = 2'(typ);
        req_addr = AW'(addr); req_val = VW'(val);
        #1;
        replay = pv && (mst[paddr] < 3);
        rdy = !replay && !(pv && typ < 2);
        chk(req_ready == rdy, "R10", "req_ready", req_ready, rdy);
        act = replay || (v && rdy);
        ms = replay ? psrc : src;
        mt = replay ? (px ? 1 : 0) : typ;
        ma = replay ? paddr : addr;
        decide(mst[ma], mown[ma], mval[ma], ms, mt, val, ns, no, nv, hold, ot, od, tag);
        ev = act && ot != 0;
        @(posedge clk);
        #1;
        if (act) begin
            if (replay) pv = 0;
            if (hold && !replay) begin pv = 1; psrc = src; paddr = addr; px = (typ == 1); end
            chk(rsp_valid == ev, "R11", "rsp_valid", rsp_valid, ev);
            if (ev) begin
                chk(rsp_type == 3'(ot), tag, "rsp_type", rsp_type, ot);
                chk(rsp_dst == IW'(od), tag, "rsp_dst", rsp_dst, od);
                chk(rsp_src == IW'(ms), tag, "rsp_src", rsp_src, ms);
                chk(rsp_addr == AW'(ma), tag, "rsp_addr", rsp_addr, ma);
                chk(rsp_val == VW'(mval[ma]), tag, "rsp_val", rsp_val, mval[ma]);
            end
            mst[ma] = ns; mown[ma] = no; mval[ma] = nv;
        end else begin
            chk(rsp_valid == 1'b0, "R11", "rsp_valid idle", rsp_valid, 0);
        end
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NL; i++) begin mst[i] = 0; mown[i] = 0; mval[i] = 0; end
        pv = 0; px = 0; psrc = 0; paddr = 0;
        rst_n = 0; req_valid = 0; req_src = 0; req_type = 0; req_addr = 0; req_val = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
        chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
        // R1: untouched line reads back value 0
        step(1, 2, 0, 5, 0);
        chk(rsp_val == 8'd0, "R1", "reset value", rsp_val, 0);
        // R2 then R12 code check
        step(1, 1, 0, 0, 0);
        chk(rsp_type == 3'd1, "R12", "shared grant code", rsp_type, 1);
        step(1, 2, 3, 0, 0);          // R8: ack from non-owner ignored
        step(1, 3, 0, 0, 0);          // R10: parked
        step(1, 2, 1, 1, 0);          // R10: refused while parked
        step(1, 1, 3, 0, 0);          // R8: owner ack settles line
        step(0, 0, 0, 0, 0);          // R10: replay gives shared forward (R6)
        step(1, 1, 2, 0, 8'h5A);      // R6: data makes line Shared
        step(1, 2, 0, 0, 0);          // R3: shared grant with 0x5A
        chk(rsp_val == 8'h5A, "R6", "value after forward data", rsp_val, 8'h5A);
        step(1, 0, 1, 2, 0);          // R4
        step(1, 0, 3, 2, 0);
        step(1, 0, 2, 2, 8'h33);      // R9
        step(1, 0, 0, 2, 0);          // R5
        chk(rsp_type == 3'd2 && rsp_val == 8'h33, "R9", "writeback kept", rsp_val, 8'h33);
        step(1, 3, 1, 2, 0);          // R7: exclusive forward
        chk(rsp_type == 3'd4, "R12", "exclusive forward code", rsp_type, 4);
        step(1, 3, 3, 2, 0);
        for (int i = 0; i < 4000; i++) begin
            int a, s, t;
            a = int'($urandom % 4);
            t = int'($urandom % 4);
            s = int'($urandom % NP);
            if (t >= 2 && ($urandom % 3) != 0) s = mown[a];
            step(($urandom % 4) != 0, s, t, a, int'($urandom % 256));
        end
        @(negedge clk); req_valid = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule